// File: doc/BRIEF.md
# Register Write-Hazard Scoreboard

This block keeps one pending-write bit for every architectural register. Several requesters (execution units) share it. When a unit is issued an instruction that will write a register, that register's bit goes high. The bit drops again when the register file write for that register is granted. A unit can also finish without producing a result, and in that case the bit is dropped too. Each requester can ask whether a source register it wants to read still has a write in flight. The answer is flagged per requester, and also as one combined hazard on a shared check port.

Register numbers arrive either as binary indices or as one-hot vectors, chosen by the `UNARY` parameter. Binary numbers are decoded to one-hot inside the block. All per-requester set, clear and check enables are OR-combined onto one shared vector of each kind.

Top module: `hazard_scoreboard`

## Requirements
- R1: While reset is asserted, and after it is released, every pending bit is 0.
- R2: In a cycle where a requester has `iss_sel` and `iss_wflag` high, the bit of its destination register reads 1 after the next clock edge. With `iss_sel` high and `iss_wflag` low, no bit changes. In binary mode, register number n maps to bit n.
- R3: A requester with `wr_grant` high clears the bit of `wr_dst` at the next clock edge. Bits that are neither set nor cleared keep their value.
- R4: If the same bit is set and cleared in the same cycle, it reads 1 afterwards.
- R5: A requester that raises `done` with `res_ok` low, while its write flag latched at issue is set, clears the destination register captured at issue. With `res_ok` high, `done` clears nothing.
- R6: The latched write flag is dropped in any non-issue cycle where `busy` is low. A later `done` with `res_ok` low then clears nothing.
- R7: `hazard[i]` is high, in the same cycle, exactly when `chk_act[i]` is high and the bit of `chk_src` for requester i is set.
- R8: `chk_en` is the OR over requesters of the one-hot of `chk_src`. A requester contributes only when its `chk_act` is high, and not when `busy` is high while no hazard is seen for it.
- R9: `any_hazard` is high exactly when `pending AND chk_en` is nonzero. This equals the OR of all `hazard` bits.
- R10: Sets and clears from different requesters in the same cycle all take effect together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iss_sel | input | NREQ | Requester selected for issue this cycle |
| iss_wflag | input | NREQ | Issued instruction writes a register |
| iss_dst | input | NREQ*RW | Destination register per requester |
| wr_grant | input | NREQ | Register-file write port granted |
| wr_dst | input | NREQ*RW | Register being written per requester |
| busy | input | NREQ | Requester is executing |
| done | input | NREQ | Requester finished this cycle |
| res_ok | input | NREQ | Finished requester has a valid result |
| chk_act | input | NREQ | Requester is checking a source register |
| chk_src | input | NREQ*RW | Source register per requester |
| pending | output | NREG | Stored pending-write bits |
| hazard | output | NREQ | Per-requester read-after-write hazard |
| chk_en | output | NREG | Shared check-enable vector |
| any_hazard | output | 1 | Hazard on the shared check port |

## Verification
The bench targets several corner cases.

- **Set and clear colliding on one bit.** A design that gives clear priority would silently lose a fresh issue.
- **A unit that completes without a result.** A design missing the completion path would leave a stuck hazard bit.
- **A completion arriving after busy has dropped.** A design that never resets its latched write flag would wrongly clear a bit belonging to a newer writer.
- **The check-enable drop for busy units.** A design that drops the enable while a hazard is still visible would let a read through too early.
- **Simultaneous traffic from several requesters.** This exposes an OR-reduction that keeps only one requester.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  // Binary register number to a one-hot position test.
  function automatic logic hzd_sel_bit(input logic [31:0] code, input int unsigned k);
    return code == k;
  endfunction

  // Nonzero overlap of two masks, given as 32-bit chunks folded by the caller.
  function automatic logic hzd_overlap(input logic a, input logic b);
    return a & b;
  endfunction
endpackage

// File: rtl/hzd_decode.sv
module hzd_decode #(
  parameter int NREG  = 32,
  parameter bit UNARY = 1'b0,
  parameter int RW    = 5
) (
  input  logic [RW-1:0]   code,
  output logic [NREG-1:0] hot
);
  import hzd_pkg::*;
  generate
    if (UNARY) begin : g_unary
      assign hot = code;
    end else begin : g_binary
      always_comb begin
        for (int k = 0; k < NREG; k++) hot[k] = hzd_sel_bit(32'(code), k);
      end
    end
  endgenerate
endmodule

// File: rtl/hzd_req.sv
module hzd_req #(
  parameter int NREG  = 32,
  parameter bit UNARY = 1'b0,
  parameter int RW    = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_sel,
  input  logic            iss_wflag,
  input  logic [RW-1:0]   iss_dst,
  input  logic            wr_grant,
  input  logic [RW-1:0]   wr_dst,
  input  logic            busy,
  input  logic            done,
  input  logic            res_ok,
  input  logic            chk_act,
  input  logic [RW-1:0]   chk_src,
  input  logic [NREG-1:0] pending,
  output logic [NREG-1:0] set_hot,
  output logic [NREG-1:0] clr_hot,
  output logic [NREG-1:0] chk_hot,
  output logic            hazard
);
  import hzd_pkg::*;

  logic [NREG-1:0] iss_hot, wr_hot, src_hot, lat_hot;
  logic            lat_wflag;
  logic            nores_clr;
  logic            raw_seen;
  logic            chk_keep;

  hzd_decode #(.NREG(NREG), .UNARY(UNARY), .RW(RW)) u_dec_iss (.code(iss_dst), .hot(iss_hot));
  hzd_decode #(.NREG(NREG), .UNARY(UNARY), .RW(RW)) u_dec_wr  (.code(wr_dst),  .hot(wr_hot));
  hzd_decode #(.NREG(NREG), .UNARY(UNARY), .RW(RW)) u_dec_src (.code(chk_src), .hot(src_hot));

  // Write flag and destination captured at issue; flag dropped once idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_wflag <= 1'b0;
      lat_hot   <= '0;
    end else if (iss_sel) begin
      lat_wflag <= iss_wflag;
      lat_hot   <= iss_hot;
    end else if (!busy) begin
      lat_wflag <= 1'b0;
    end
  end

  assign nores_clr = done & lat_wflag & ~res_ok;
  assign set_hot   = (iss_sel & iss_wflag) ? iss_hot : '0;
  assign clr_hot   = (wr_grant ? wr_hot : '0) | (nores_clr ? lat_hot : '0);

  assign raw_seen  = |(pending & src_hot);
  assign hazard    = hzd_overlap(chk_act, raw_seen);
  assign chk_keep  = chk_act & ~(busy & ~raw_seen);
  assign chk_hot   = chk_keep ? src_hot : '0;
endmodule

// File: rtl/hzd_bits.sv
module hzd_bits #(
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] set_vec,
  input  logic [NREG-1:0] clr_vec,
  output logic [NREG-1:0] pending
);
  // Set overrides clear on the same bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else        pending <= (pending & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/hazard_scoreboard.sv
module hazard_scoreboard #(
  parameter int NREG  = 32,
  parameter int NREQ  = 4,
  parameter bit UNARY = 1'b0,
  localparam int AW   = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int RW   = UNARY ? NREG : AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREQ-1:0]    iss_sel,
  input  logic [NREQ-1:0]    iss_wflag,
  input  logic [NREQ*RW-1:0] iss_dst,
  input  logic [NREQ-1:0]    wr_grant,
  input  logic [NREQ*RW-1:0] wr_dst,
  input  logic [NREQ-1:0]    busy,
  input  logic [NREQ-1:0]    done,
  input  logic [NREQ-1:0]    res_ok,
  input  logic [NREQ-1:0]    chk_act,
  input  logic [NREQ*RW-1:0] chk_src,
  output logic [NREG-1:0]    pending,
  output logic [NREQ-1:0]    hazard,
  output logic [NREG-1:0]    chk_en,
  output logic               any_hazard
);
  logic [NREQ-1:0][NREG-1:0] set_each, clr_each, chk_each;
  logic [NREG-1:0]           set_vec, clr_vec;

  generate
    for (genvar g = 0; g < NREQ; g++) begin : g_req
      hzd_req #(.NREG(NREG), .UNARY(UNARY), .RW(RW)) u_req (
        .clk(clk), .rst_n(rst_n),
        .iss_sel(iss_sel[g]), .iss_wflag(iss_wflag[g]), .iss_dst(iss_dst[g*RW +: RW]),
        .wr_grant(wr_grant[g]), .wr_dst(wr_dst[g*RW +: RW]),
        .busy(busy[g]), .done(done[g]), .res_ok(res_ok[g]),
        .chk_act(chk_act[g]), .chk_src(chk_src[g*RW +: RW]),
        .pending(pending),
        .set_hot(set_each[g]), .clr_hot(clr_each[g]), .chk_hot(chk_each[g]),
        .hazard(hazard[g])
      );
    end
  endgenerate

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    chk_en  = '0;
    for (int r = 0; r < NREQ; r++) begin
      set_vec = set_vec | set_each[r];
      clr_vec = clr_vec | clr_each[r];
      chk_en  = chk_en  | chk_each[r];
    end
  end

  assign any_hazard = |(pending & chk_en);

  hzd_bits #(.NREG(NREG)) u_bits (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .pending(pending)
  );
endmodule

// File: rtl/hzd_sb_chk.sv
module hzd_sb_chk #(
  parameter int NREG = 32,
  parameter int NREQ = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREG-1:0] pending,
  input logic [NREG-1:0] set_vec,
  input logic [NREG-1:0] clr_vec,
  input logic [NREQ-1:0] hazard,
  input logic            any_hazard
);
  assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |=> pending == '0);

  assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((pending & $past(set_vec)) == $past(set_vec)));

  assert_clear_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((pending & $past(clr_vec & ~set_vec)) == '0));

  assert_untouched_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pending ^ $past(pending)) & ~$past(set_vec | clr_vec)) == '0));

  assert_set_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & clr_vec) != '0) |=> ((pending & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));

  assert_shared_matches_each_R9: assert property (@(posedge clk) disable iff (!rst_n)
    any_hazard == (|hazard));
endmodule

bind hazard_scoreboard hzd_sb_chk #(.NREG(NREG), .NREQ(NREQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .pending(pending), .set_vec(set_vec),
  .clr_vec(clr_vec), .hazard(hazard), .any_hazard(any_hazard)
);

// File: tb/hazard_scoreboard_tb.sv
module hazard_scoreboard_tb;
  localparam int NREG = 32;
  localparam int NREQ = 4;
  localparam int AW   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NREQ-1:0] iss_sel, iss_wflag, wr_grant, busy, done, res_ok, chk_act;
  int              d_iss [NREQ];
  int              d_wr  [NREQ];
  int              d_src [NREQ];
  logic [NREQ*AW-1:0] iss_dst, wr_dst, chk_src;
  logic [NREG-1:0] pending, chk_en;
  logic [NREQ-1:0] hazard;
  logic            any_hazard;

  always_comb begin
    for (int u = 0; u < NREQ; u++) begin
      iss_dst[u*AW +: AW] = AW'(d_iss[u]);
      wr_dst[u*AW +: AW]  = AW'(d_wr[u]);
      chk_src[u*AW +: AW] = AW'(d_src[u]);
    end
  end

  hazard_scoreboard u_dut (
    .clk(clk), .rst_n(rst_n), .iss_sel(iss_sel), .iss_wflag(iss_wflag), .iss_dst(iss_dst),
    .wr_grant(wr_grant), .wr_dst(wr_dst), .busy(busy), .done(done), .res_ok(res_ok),
    .chk_act(chk_act), .chk_src(chk_src), .pending(pending), .hazard(hazard),
    .chk_en(chk_en), .any_hazard(any_hazard)
  );

  // Reference state
  bit m_bits [NREG];
  bit m_lat  [NREQ];
  int m_ldst [NREQ];
  int n_checks = 0;
  int n_fail   = 0;
  string tag = "R1";

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    iss_sel = '0; iss_wflag = '0; wr_grant = '0; done = '0; res_ok = '0; chk_act = '0;
    for (int u = 0; u < NREQ; u++) begin d_iss[u] = 0; d_wr[u] = 0; d_src[u] = 0; end
  endtask

  // Compare all outputs mid-cycle, then advance the model across one edge.
  task automatic step();
    logic [31:0] e_pend, e_en, e_haz;
    bit clr [NREG];
    bit st  [NREG];
    #1;
    e_pend = '0; e_en = '0; e_haz = '0;
    for (int k = 0; k < NREG; k++) e_pend[k] = m_bits[k];
    for (int u = 0; u < NREQ; u++) begin
      if (chk_act[u] && m_bits[d_src[u]]) e_haz[u] = 1'b1;
      if (chk_act[u] && !(busy[u] && !m_bits[d_src[u]])) e_en[d_src[u]] = 1'b1;
    end
    chk("pending", pending, e_pend);
    chk("hazard", 32'(hazard), e_haz);
    chk("chk_en", chk_en, e_en);
    chk("any_hazard", 32'(any_hazard), 32'((e_pend & e_en) != 0));
    @(posedge clk);
    for (int k = 0; k < NREG; k++) begin clr[k] = 0; st[k] = 0; end
    for (int u = 0; u < NREQ; u++) begin
      if (wr_grant[u]) clr[d_wr[u]] = 1;
      if (done[u] && m_lat[u] && !res_ok[u]) clr[m_ldst[u]] = 1;
      if (iss_sel[u] && iss_wflag[u]) st[d_iss[u]] = 1;
    end
    for (int k = 0; k < NREG; k++) begin
      if (clr[k]) m_bits[k] = 0;
      if (st[k])  m_bits[k] = 1;
    end
    for (int u = 0; u < NREQ; u++) begin
      if (iss_sel[u]) begin m_lat[u] = iss_wflag[u]; m_ldst[u] = d_iss[u]; end
      else if (!busy[u]) m_lat[u] = 0;
    end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    idle();
    busy = '0;
    for (int k = 0; k < NREG; k++) m_bits[k] = 0;
    for (int u = 0; u < NREQ; u++) begin m_lat[u] = 0; m_ldst[u] = 0; end
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("pending in reset", pending, 32'h0);
    rst_n = 1'b1;
    step();

    // R2: write-flag issue sets; issue without write flag does nothing
    tag = "R2";
    iss_sel = 4'b0011; iss_wflag = 4'b0001; d_iss[0] = 5; d_iss[1] = 9;
    step(); idle(); busy = 4'b0011;
    step();
    chk("bit5 set, bit9 clear", pending & 32'h220, 32'h20);

    // R10: two requesters set together
    tag = "R10";
    iss_sel = 4'b1100; iss_wflag = 4'b1100; d_iss[2] = 0; d_iss[3] = 31;
    step(); idle(); busy = 4'b1111;
    step();

    // R7 and R8: check port with and without busy
    tag = "R7";
    chk_act = 4'b0010; d_src[1] = 5; busy[1] = 1'b0; step();
    busy[1] = 1'b1; step();
    tag = "R8";
    d_src[1] = 6; step();
    busy[1] = 1'b0; step();
    chk("enable for idle unit", chk_en, 32'h40);
    idle(); busy = 4'b1111;

    // R3: write grant clears
    tag = "R3";
    wr_grant = 4'b0001; d_wr[0] = 5; step(); idle(); step();

    // R4: set and clear same bit, same cycle
    tag = "R4";
    iss_sel = 4'b0001; iss_wflag = 4'b0001; d_iss[0] = 7;
    wr_grant = 4'b0010; d_wr[1] = 7;
    step(); idle(); step();
    chk("bit7 survives", 32'(pending[7]), 32'h1);

    // R5: done without result clears; done with result does not
    tag = "R5";
    done = 4'b1100; res_ok = 4'b1000; step(); idle(); step();
    chk("bit0 cleared, bit31 kept", pending & 32'h8000_0001, 32'h8000_0000);

    // R6: latch dropped when idle, late done clears nothing
    tag = "R6";
    iss_sel = 4'b0001; iss_wflag = 4'b0001; d_iss[0] = 12; busy[0] = 1'b0;
    step(); idle(); step();
    done = 4'b0001; busy[0] = 1'b1; step(); idle(); step();
    chk("bit12 kept", 32'(pending[12]), 32'h1);

    // R9: mixed random traffic against the model
    tag = "R9";
    for (int n = 0; n < 400; n++) begin
      iss_sel = 4'($urandom); iss_wflag = 4'($urandom); wr_grant = 4'($urandom);
      busy = 4'($urandom); done = 4'($urandom); res_ok = 4'($urandom); chk_act = 4'($urandom);
      for (int u = 0; u < NREQ; u++) begin
        d_iss[u] = int'($urandom_range(0, NREG-1));
        d_wr[u]  = int'($urandom_range(0, NREG-1));
        d_src[u] = int'($urandom_range(0, NREG-1));
      end
      step();
    end
    idle();

    tag = "R1";
    rst_n = 1'b0; #1;
    chk("pending after re-reset", pending, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule